// File: doc/BRIEF.md
# ADC Result DMA Address Generator

This block sits between an analog-to-digital converter and a DMA engine and decides where each conversion result lands in data memory. It receives one result at a time, tagged with the channel it was taken from. It emits one memory write request per result, carrying a 16-bit address and the result zero-extended to 16 bits.

In indirect mode, memory is treated as a row of equal channel buffers, each 2^code words long, where code is a 3-bit length setting. The block packs the channel number and a per-channel word index into an 11-bit offset and ORs that offset onto a base address. Each channel owns an index counter. The counter steps on every write to that channel and wraps to zero after a programmed number of writes. The base address must leave clear every bit the offset can use; a flag reports any overlap. In direct mode, every result goes to the base address itself.

Results enter on a valid/ready handshake and leave on a valid/ready handshake. There is a single output register. A new result is taken only when that register is empty, or is being emptied in the same cycle: `conv_ready = !wr_valid || wr_ready`. While `wr_valid` is high and `wr_ready` is low, the request and its payload stay frozen. Configuration pins are plain levels.

Top module: `adc_ia_gen`

## Requirements
- R1: After reset, `wr_valid` is 0, `conv_ready` is 1 and every channel's word index is 0.
- R2: In indirect mode (`dir_mode` = 0), the address is `base_addr` OR a zero-extended 11-bit offset. The offset holds the channel in bits starting at position code+1, the word index in bits code..1, and 0 in bit 0. With code 2 and base 1000h, the first results of channels 1, 3 and 8 go to 1008h, 1018h and 1040h.
- R3: The channel field is 5 bits wide for codes 0 to 5, 4 bits for code 6 and 3 bits for code 7. In indirect mode, a result whose channel does not fit that field is accepted and discarded, with no write request.
- R4: In indirect mode, each write steps that channel's index by one. The index returns to 0 after min(`wrap_cnt`+1, 2^code) writes. Other channels' indices are unaffected.
- R5: In direct mode (`dir_mode` = 1), the address equals `base_addr`, every channel number 0 to 31 is written, and no index moves.
- R6: A change of `dir_mode` or `len_code` returns every index to 0 on the next clock edge.
- R7: `mask_err` is 1 exactly when `dir_mode` = 0 and `base_addr` has a 1 in any of bits 1 to (channel width + code).
- R8: `wr_data` equals `conv_data` with bits 15:12 zero.
- R9: `conv_ready = !wr_valid || wr_ready`. While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold.
- R10: A result taken at a clock edge produces its write request, with `wr_valid` high, from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_mode | input | 1 | 1 selects direct mode, 0 selects indirect mode |
| len_code | input | 3 | Buffer length code; 2^code words per channel |
| wrap_cnt | input | 7 | Writes per index cycle, minus one |
| base_addr | input | 16 | Base destination address |
| conv_valid | input | 1 | Conversion result offered |
| conv_ready | output | 1 | Block can take a result this cycle |
| conv_chan | input | 5 | Channel number of the result |
| conv_data | input | 12 | Conversion result |
| wr_valid | output | 1 | Write request pending |
| wr_ready | input | 1 | Write request taken by the DMA side |
| wr_addr | output | 16 | Write address |
| wr_data | output | 16 | Write data, zero-extended result |
| mask_err | output | 1 | Base address overlaps the offset bits |

## Verification
The assertions take for granted that `len_code`, `dir_mode`, `wrap_cnt` and `base_addr` stay steady from the moment a result is offered until the cycle after it is taken. They also assume `conv_chan` and `conv_data` stay steady while `conv_valid` waits. The stimulus changes configuration only between results and then idles for a cycle. It holds each offered result until `conv_ready` is seen high. Back-pressure comes from a pseudo-random `wr_ready` pattern, so held requests, and results taken in the same cycle a request drains, both occur.

// File: rtl/adc_ia_pkg.sv
package adc_ia_pkg;
  localparam int CODE_W = 3;
  localparam int CHAN_W = 5;
  localparam int NCHAN  = 1 << CHAN_W;
  localparam int OFS_W  = 11;
  localparam int ADDR_W = 16;
  localparam int RES_W  = 12;
  localparam int IDX_W  = (1 << CODE_W) - 1;

  // width of the channel field for a given length code
  function automatic logic [3:0] chan_width(input logic [CODE_W-1:0] code);
    logic [3:0] room;
    room = 4'(OFS_W - 1) - 4'(code);
    return (room > 4'(CHAN_W)) ? 4'(CHAN_W) : room;
  endfunction
endpackage

// File: rtl/adc_ia_pack.sv
module adc_ia_pack
  import adc_ia_pkg::*;
(
  input  logic              dir_mode,
  input  logic [CODE_W-1:0] len_code,
  input  logic [CHAN_W-1:0] chan,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic              mask_err
);
  logic [3:0]       cw;
  logic [3:0]       top_sh;
  logic [OFS_W-1:0] ofs;
  logic [OFS_W-1:0] one_sh;
  logic [OFS_W-1:0] used;

  always_comb begin
    cw       = chan_width(len_code);
    in_range = dir_mode || ((32'(chan) >> cw) == 32'd0);
    ofs      = (OFS_W'(chan) << (4'(len_code) + 4'd1))
             | (OFS_W'(idx) << 1);
    top_sh   = cw + 4'(len_code) + 4'd1;
    one_sh   = OFS_W'(1) << top_sh;
    used     = (one_sh - OFS_W'(1)) & ~OFS_W'(1);
    mask_err = !dir_mode && |(base_addr[OFS_W-1:0] & used);
    addr     = dir_mode ? base_addr : (base_addr | ADDR_W'(ofs));
  end
endmodule

// File: rtl/adc_ia_index_bank.sv
module adc_ia_index_bank
  import adc_ia_pkg::*;
#(
  parameter int N_CH = NCHAN,
  parameter int IW   = IDX_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CODE_W-1:0]        len_code,
  input  logic [IW-1:0]            wrap_cnt,
  input  logic                     clr,
  input  logic                     hit,
  input  logic [$clog2(N_CH)-1:0]  chan,
  output logic [IW-1:0]            idx_rd
);
  localparam int LW = IW + 1;

  logic [IW-1:0] cnt [N_CH];
  logic [LW-1:0] words;
  logic [LW-1:0] lim;

  always_comb begin
    words = LW'(1) << len_code;
    lim   = (LW'(wrap_cnt) + LW'(1) < words) ? LW'(wrap_cnt) + LW'(1) : words;
  end

  function automatic logic [IW-1:0] step(input logic [IW-1:0] v, input logic [LW-1:0] l);
    return (LW'(v) + LW'(1) >= l) ? '0 : v + IW'(1);
  endfunction

  assign idx_rd = clr ? '0 : cnt[chan];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic sel;
    assign sel = hit && (chan == ($clog2(N_CH))'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt[i] <= '0;
      else if (clr) cnt[i] <= sel ? step('0, lim) : '0;
      else if (sel) cnt[i] <= step(cnt[i], lim);
    end

    // R4: an index never leaves its channel buffer
    assert_idx_in_buf_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> (LW'(cnt[i]) < words));
  end
endmodule

// File: rtl/adc_ia_gen.sv
module adc_ia_gen
  import adc_ia_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_mode,
  input  logic [2:0]        len_code,
  input  logic [6:0]        wrap_cnt,
  input  logic [15:0]       base_addr,
  input  logic              conv_valid,
  output logic              conv_ready,
  input  logic [4:0]        conv_chan,
  input  logic [11:0]       conv_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [15:0]       wr_addr,
  output logic [15:0]       wr_data,
  output logic              mask_err
);
  logic [CODE_W-1:0] code_q;
  logic              mode_q;
  logic              clr;
  logic              acc;
  logic              hit;
  logic              in_range;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_c;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= 1'b0;
    end else begin
      code_q <= len_code;
      mode_q <= dir_mode;
    end
  end

  assign clr        = (len_code != code_q) || (dir_mode != mode_q);
  assign conv_ready = !wr_valid || wr_ready;
  assign acc        = conv_valid && conv_ready;
  assign hit        = acc && in_range && !dir_mode;

  adc_ia_index_bank #(.N_CH(NCHAN), .IW(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .len_code(len_code),
    .wrap_cnt(wrap_cnt),
    .clr     (clr),
    .hit     (hit),
    .chan    (conv_chan),
    .idx_rd  (idx)
  );

  adc_ia_pack u_pack (
    .dir_mode (dir_mode),
    .len_code (len_code),
    .chan     (conv_chan),
    .idx      (idx),
    .base_addr(base_addr),
    .addr     (addr_c),
    .in_range (in_range),
    .mask_err (mask_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (acc) begin
      wr_valid <= in_range;
      wr_addr  <= addr_c;
      wr_data  <= ADDR_W'(conv_data);
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  // R9: a stalled request is frozen
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R3: out-of-range channel yields no request
  assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_range) |=> !wr_valid);

  // R10: accepted in-range result is presented next cycle
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_range) |=> wr_valid);

  // R5: direct mode writes to the base address
  assert_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && dir_mode) |=> (wr_addr == $past(base_addr)));

  // R8: upper data bits stay clear
  assert_zext_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[15:12] == 4'h0));
endmodule

// File: tb/adc_ia_gen_test.sv
module adc_ia_gen_test;
  typedef struct {
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_mode = 1'b0;
  logic [2:0]  len_code = 3'd0;
  logic [6:0]  wrap_cnt = 7'd0;
  logic [15:0] base_addr = 16'h0;
  logic        conv_valid = 1'b0;
  logic        conv_ready;
  logic [4:0]  conv_chan = 5'd0;
  logic [11:0] conv_data = 12'd0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic        mask_err;

  int   n_run = 0;
  int   n_fail = 0;
  exp_t sb[$];
  int   mcnt[32];
  bit   stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #10 clk = ~clk;

  adc_ia_gen uut (
    .clk(clk), .rst_n(rst_n), .dir_mode(dir_mode), .len_code(len_code),
    .wrap_cnt(wrap_cnt), .base_addr(base_addr), .conv_valid(conv_valid),
    .conv_ready(conv_ready), .conv_chan(conv_chan), .conv_data(conv_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .mask_err(mask_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_ready <= stall_en ? lfsr[0] : 1'b1;
  end

  // monitor: pops the expected item when a request is handed over
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 unexpected write", int'(wr_addr), 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(wr_addr == e.addr, {e.tag, " addr"}, int'(wr_addr), int'(e.addr));
        check(wr_data == e.data, "R8 data", int'(wr_data), int'(e.data));
      end
    end
  end

  task automatic set_cfg(input bit m, input int code, input int wc, input int base);
    @(posedge clk); #1;
    if (m != dir_mode || 3'(code) != len_code)
      for (int i = 0; i < 32; i++) mcnt[i] = 0;   // R6 model
    dir_mode = m; len_code = 3'(code); wrap_cnt = 7'(wc); base_addr = 16'(base);
    @(posedge clk);
  endtask

  task automatic send(input int ch, input int dat, input string tag);
    int cw, lim, words;
    bit inr;
    exp_t e;
    cw    = (len_code > 5) ? 10 - int'(len_code) : 5;
    words = 1 << len_code;
    lim   = (int'(wrap_cnt) + 1 < words) ? int'(wrap_cnt) + 1 : words;
    inr   = dir_mode || (ch < (1 << cw));
    @(posedge clk); #1;
    conv_valid = 1'b1; conv_chan = 5'(ch); conv_data = 12'(dat);
    forever begin
      @(negedge clk);
      if (conv_ready) break;
    end
    if (inr) begin
      if (dir_mode) e.addr = base_addr;
      else e.addr = base_addr | 16'((ch << (len_code + 1)) | (mcnt[ch] << 1));
      e.data = 16'(dat & 12'hFFF);
      e.tag  = tag;
      sb.push_back(e);
      if (!dir_mode) mcnt[ch] = (mcnt[ch] + 1 >= lim) ? 0 : mcnt[ch] + 1;
    end
    @(posedge clk); #1;
    conv_valid = 1'b0;
    @(negedge clk);
    check(wr_valid == inr, inr ? "R10 latency" : "R3 drop", int'(wr_valid), int'(inr));
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && sb.size() != 0; i++) @(posedge clk);
    repeat (3) @(posedge clk);
    check(sb.size() == 0, "R9 drained", sb.size(), 0);
  endtask

  initial begin
    #(20 * 20000);
    check(1'b0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mcnt[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(wr_valid == 1'b0, "R1 wr_valid", int'(wr_valid), 0);
    check(conv_ready == 1'b1, "R1 conv_ready", int'(conv_ready), 1);
    rst_n = 1'b1;

    // R2: example layout, 4-word buffers at 1000h
    set_cfg(0, 2, 3, 'h1000);
    @(negedge clk);
    check(mask_err == 1'b0, "R7 aligned", int'(mask_err), 0);
    send(1, 'h111, "R2");
    send(3, 'h333, "R2");
    send(8, 'h888, "R2");
    // R4: channel 1 steps and wraps after 4 writes
    for (int k = 0; k < 4; k++) send(1, 'h100 + k, "R4");
    // R1: a channel never written starts at index 0
    send(31, 'hFFF, "R1");
    drain();

    // R7 mask checks
    set_cfg(0, 2, 3, 'h1004);
    @(negedge clk);
    check(mask_err == 1'b1, "R7 overlap bit2", int'(mask_err), 1);
    set_cfg(0, 2, 3, 'h1100);
    @(negedge clk);
    check(mask_err == 1'b0, "R7 bit8 free", int'(mask_err), 0);
    set_cfg(0, 7, 0, 'h0400);
    @(negedge clk);
    check(mask_err == 1'b1, "R7 code7 bit10", int'(mask_err), 1);
    set_cfg(1, 7, 0, 'h0400);
    @(negedge clk);
    check(mask_err == 1'b0, "R7 direct", int'(mask_err), 0);

    // R4: short wrap count, code 3
    set_cfg(0, 3, 1, 'h2000);
    for (int k = 0; k < 5; k++) send(2, 'h20 + k, "R4");
    drain();

    // R3: channel field width at codes 7 and 6
    set_cfg(0, 7, 127, 'h0800);
    send(7, 'h7, "R3");
    send(8, 'h8, "R3");
    send(7, 'h77, "R4");
    set_cfg(0, 6, 127, 'h0800);
    send(15, 'hF, "R3");
    send(16, 'h10, "R3");
    drain();

    // R6: change code, indices restart
    set_cfg(0, 2, 3, 'h1000);
    send(5, 'h51, "R6");
    send(5, 'h52, "R6");
    set_cfg(0, 3, 7, 'h1000);
    send(5, 'h53, "R6");
    drain();

    // R5: direct mode
    set_cfg(1, 2, 3, 'h3456);
    send(31, 'hABC, "R5");
    send(31, 'hABD, "R5");
    send(0, 'h001, "R5");
    drain();

    // R9: back-pressure with a mixed burst
    set_cfg(0, 1, 1, 'h4000);
    stall_en = 1'b1;
    for (int k = 0; k < 24; k++) send(k % 6, 'hC00 + k, "R9");
    stall_en = 1'b0;
    drain();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule